// File: doc/BRIEF.md
# Per-Channel Conversion Ready Tracker

This block sits between a multi-channel converter core and its serial port. It keeps one result register, one status byte and one unread flag for each of eight channels. It drives one active-low ready pin that tells the host when results are waiting. A completed conversion writes its channel's registers and raises that channel's flag. The serial port marks the start and the end of a result read, and the end of the read clears the flag.

A configuration input picks how the pin combines the flags. In "any" mode the pin goes low as soon as one channel has an unread result. In "all" mode the pin goes low only when every enabled channel has one. A result that lands on a channel whose previous result was never read replaces the old one. The block then forces the pin high for a fixed blackout time so that the host can see the loss, and after that it re-raises the flag. A result that arrives for the channel currently being read is dropped, so the word being shifted out cannot change mid-read. A write of the mode register clears all tracking state.

Top module: `rdy_flag_mgr`

## Requirements
- R1: After reset every flag in `rdy_flags` is 0, `rdy_n` is 1 and every channel's stored result and status byte read back as 0.
- R2: A `conv_done` pulse on channel c (with no collision and no mode write) stores `conv_result` and a status byte whose bits [2:0] hold c and bits [7:3] are 0, and sets `rdy_flags[c]` from the following cycle on.
- R3: A read of channel c (`rd_start` with `rd_chan`=c, later `rd_end`) clears `rdy_flags[c]` after the `rd_end` cycle and leaves the other flags unchanged.
- R4: With `all_mode`=0, `rdy_n` is low exactly when at least one flag is set and no loss blackout is running.
- R5: With `all_mode`=1, `rdy_n` is low only when `chan_en` is nonzero and every channel enabled in `chan_en` has its flag set. With `chan_en`=0 the pin stays high.
- R6: A result for a channel whose previous result is unread overwrites the stored result and clears that flag. `rdy_n` is then high for exactly HOLD_CYCLES cycles (163 by default), after which the flag is set again and the pin follows R4/R5.
- R7: A `conv_done` for the channel being read, at any cycle from its `rd_start` through its `rd_end`, is discarded. The stored result and the flag stay as they were, and the read still clears the flag.
- R8: A `mode_wr` pulse clears all flags, cancels any running blackout together with its pending re-raise, and makes `rdy_n` high from the next cycle.
- R9: A `conv_done` in the same cycle as `mode_wr` is discarded and the stored result is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 1 | One-cycle conversion completion strobe |
| conv_chan | input | 3 | Channel of the completed conversion |
| conv_result | input | 24 | Result of the completed conversion |
| rd_start | input | 1 | Serial port begins reading a channel's result |
| rd_end | input | 1 | Serial port finished that read |
| rd_chan | input | 3 | Channel addressed by the read; selects read-out mux |
| mode_wr | input | 1 | Mode register write pulse |
| all_mode | input | 1 | 0: pin low on any unread; 1: pin low when all enabled are unread |
| chan_en | input | 8 | Enabled-channel mask for the "all" rule |
| rd_data | output | 24 | Stored result of channel `rd_chan` |
| rd_status | output | 8 | Status byte of channel `rd_chan` |
| rdy_flags | output | 8 | Per-channel unread flags |
| rdy_n | output | 1 | Active-low ready pin |

## Verification
The assertions assume well-formed reads. Each `rd_end` follows its own `rd_start` with no second start between them, `rd_chan` is held for the whole read, and `chan_en` changes only while no result is in flight. They also take `conv_chan` to always name an existing channel. The stimulus drives every input on the falling edge and runs one read at a time through a single task. It places conversions inside a read window only in the collision cases it sets up on purpose, so the checker's own model of the read window stays in step with the design's.

// File: rtl/rdy_flag_pkg.sv
package rdy_flag_pkg;
  localparam int STAT_W = 8;

  // Status byte: channel number in the low bits, remaining bits zero.
  function automatic logic [STAT_W-1:0] mk_status(input logic [STAT_W-1:0] chan);
    return chan;
  endfunction
endpackage

// File: rtl/rdy_chan_bank.sv
module rdy_chan_bank
  import rdy_flag_pkg::*;
#(
  parameter int N_CH  = 8,
  parameter int RES_W = 24,
  parameter int CH_W  = $clog2(N_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_chan,
  input  logic [RES_W-1:0]  wr_data,
  input  logic [CH_W-1:0]   sel_chan,
  output logic [RES_W-1:0]  sel_data,
  output logic [STAT_W-1:0] sel_status
);
  logic [RES_W-1:0]  res_q  [N_CH];
  logic [STAT_W-1:0] stat_q [N_CH];

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic ch_we;
    assign ch_we = wr_en && (wr_chan == CH_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_q[g]  <= '0;
        stat_q[g] <= '0;
      end else if (ch_we) begin
        res_q[g]  <= wr_data;
        stat_q[g] <= mk_status(STAT_W'(g));
      end
    end
  end

  assign sel_data   = res_q[sel_chan];
  assign sel_status = stat_q[sel_chan];
endmodule

// File: rtl/rdy_loss_timer.sv
module rdy_loss_timer #(
  parameter int HOLD_CYCLES = 163,
  parameter int CNT_W       = $clog2(HOLD_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic clr,
  output logic active,
  output logic expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                cnt_d = '0;
    else if (load)          cnt_d = CNT_W'(HOLD_CYCLES);
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);
  assign expire = (cnt_q == CNT_W'(1)) && !load && !clr;
endmodule

// File: rtl/rdy_pin_logic.sv
module rdy_pin_logic #(
  parameter int N_CH = 8
) (
  input  logic [N_CH-1:0] flags,
  input  logic [N_CH-1:0] chan_en,
  input  logic            all_mode,
  input  logic            blackout,
  output logic            pin_n
);
  logic any_ready, all_ready;

  always_comb begin
    any_ready = |flags;
    all_ready = (chan_en != '0) && ((flags & chan_en) == chan_en);
    pin_n     = blackout || !(all_mode ? all_ready : any_ready);
  end
endmodule

// File: rtl/rdy_flag_mgr.sv
module rdy_flag_mgr
  import rdy_flag_pkg::*;
#(
  parameter int N_CH        = 8,
  parameter int RES_W       = 24,
  parameter int HOLD_CYCLES = 163,
  localparam int CH_W       = $clog2(N_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_done,
  input  logic [CH_W-1:0]   conv_chan,
  input  logic [RES_W-1:0]  conv_result,
  input  logic              rd_start,
  input  logic              rd_end,
  input  logic [CH_W-1:0]   rd_chan,
  input  logic              mode_wr,
  input  logic              all_mode,
  input  logic [N_CH-1:0]   chan_en,
  output logic [RES_W-1:0]  rd_data,
  output logic [STAT_W-1:0] rd_status,
  output logic [N_CH-1:0]   rdy_flags,
  output logic              rdy_n
);
  logic [N_CH-1:0] flag_q, flag_d, pend_q, pend_d, rd_clr;
  logic            rd_act_q, rd_act_d;
  logic [CH_W-1:0] rd_ch_q, rd_ch_d;
  logic            collide, take, lose, blackout, expire;

  // Read window tracking
  always_comb begin
    rd_act_d = rd_act_q;
    rd_ch_d  = rd_ch_q;
    if (rd_start) begin
      rd_act_d = 1'b1;
      rd_ch_d  = rd_chan;
    end else if (rd_end) begin
      rd_act_d = 1'b0;
    end
  end

  always_comb begin
    collide = conv_done && ((rd_start && (conv_chan == rd_chan)) ||
                            (rd_act_q && (conv_chan == rd_ch_q)));
    take    = conv_done && !mode_wr && !collide;
    lose    = take && (flag_q[conv_chan] || pend_q[conv_chan]);
    rd_clr  = (rd_end && rd_act_q) ? (N_CH'(1) << rd_ch_q) : '0;
  end

  // Flag and pending next state
  always_comb begin
    flag_d = flag_q;
    pend_d = pend_q;
    if (mode_wr) begin
      flag_d = '0;
      pend_d = '0;
    end else begin
      if (expire) begin
        flag_d = flag_d | pend_q;
        pend_d = '0;
      end
      if (take) begin
        flag_d[conv_chan] = !lose;
        if (lose) pend_d[conv_chan] = 1'b1;
      end
      flag_d = flag_d & ~rd_clr;
      pend_d = pend_d & ~rd_clr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q   <= '0;
      pend_q   <= '0;
      rd_act_q <= 1'b0;
      rd_ch_q  <= '0;
    end else begin
      flag_q   <= flag_d;
      pend_q   <= pend_d;
      rd_act_q <= rd_act_d;
      rd_ch_q  <= rd_ch_d;
    end
  end

  rdy_chan_bank #(.N_CH(N_CH), .RES_W(RES_W), .CH_W(CH_W)) bank_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(take), .wr_chan(conv_chan), .wr_data(conv_result),
    .sel_chan(rd_chan), .sel_data(rd_data), .sel_status(rd_status)
  );

  rdy_loss_timer #(.HOLD_CYCLES(HOLD_CYCLES)) timer_i (
    .clk(clk), .rst_n(rst_n),
    .load(lose), .clr(mode_wr),
    .active(blackout), .expire(expire)
  );

  rdy_pin_logic #(.N_CH(N_CH)) pin_i (
    .flags(flag_q), .chan_en(chan_en), .all_mode(all_mode),
    .blackout(blackout), .pin_n(rdy_n)
  );

  assign rdy_flags = flag_q;
endmodule

// File: rtl/rdy_flag_mgr_chk.sv
module rdy_flag_mgr_chk #(
  parameter int N_CH        = 8,
  parameter int HOLD_CYCLES = 163,
  parameter int CH_W        = $clog2(N_CH)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            conv_done,
  input logic [CH_W-1:0] conv_chan,
  input logic            rd_start,
  input logic            rd_end,
  input logic [CH_W-1:0] rd_chan,
  input logic            mode_wr,
  input logic            all_mode,
  input logic [N_CH-1:0] chan_en,
  input logic [N_CH-1:0] rdy_flags,
  input logic            rdy_n
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);

  logic            c_act;
  logic [CH_W-1:0] c_ch;
  logic [CW-1:0]   c_cnt;
  logic            c_hit, c_ovr;

  assign c_hit = conv_done && ((rd_start && conv_chan == rd_chan) || (c_act && conv_chan == c_ch));
  assign c_ovr = conv_done && !mode_wr && !c_hit && rdy_flags[conv_chan];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_act <= 1'b0;
      c_ch  <= '0;
      c_cnt <= '0;
    end else begin
      if (rd_start) begin
        c_act <= 1'b1;
        c_ch  <= rd_chan;
      end else if (rd_end) begin
        c_act <= 1'b0;
      end
      if (mode_wr)            c_cnt <= '0;
      else if (c_ovr)         c_cnt <= CW'(HOLD_CYCLES);
      else if (c_cnt != '0)   c_cnt <= c_cnt - 1'b1;
    end
  end

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_end && c_act && !rd_start && !mode_wr) |=> !rdy_flags[$past(c_ch)]); // R3

  AST_ANY_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!all_mode && rdy_flags == '0) |-> rdy_n); // R4

  AST_ALL_INCOMPLETE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (all_mode && (chan_en == '0 || (rdy_flags & chan_en) != chan_en)) |-> rdy_n); // R5

  AST_OVERWRITE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    c_ovr |=> (rdy_n && !rdy_flags[$past(conv_chan)])); // R6

  AST_BLACKOUT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (c_cnt != '0) |-> rdy_n); // R6

  AST_COLLIDE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (c_hit && !rdy_flags[conv_chan] && !mode_wr) |=> !rdy_flags[$past(conv_chan)]); // R7

  AST_MODE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (rdy_flags == '0 && rdy_n)); // R8
endmodule

bind rdy_flag_mgr rdy_flag_mgr_chk #(.N_CH(N_CH), .HOLD_CYCLES(HOLD_CYCLES), .CH_W(CH_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_chan(conv_chan),
  .rd_start(rd_start), .rd_end(rd_end), .rd_chan(rd_chan), .mode_wr(mode_wr),
  .all_mode(all_mode), .chan_en(chan_en), .rdy_flags(rdy_flags), .rdy_n(rdy_n)
);

// File: tb/rdy_flag_mgr_tb_top.sv
module rdy_flag_mgr_tb_top;
  localparam int HOLD = 163;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_done = 1'b0;
  logic [2:0]  conv_chan = '0;
  logic [23:0] conv_result = '0;
  logic        rd_start = 1'b0, rd_end = 1'b0;
  logic [2:0]  rd_chan = '0;
  logic        mode_wr = 1'b0, all_mode = 1'b0;
  logic [7:0]  chan_en = 8'h03;
  logic [23:0] rd_data;
  logic [7:0]  rd_status;
  logic [7:0]  rdy_flags;
  logic        rdy_n;

  int n_run = 0, n_fail = 0;

  typedef struct packed { logic [23:0] d; logic [7:0] s; } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  rdy_flag_mgr dut_i (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_chan(conv_chan),
    .conv_result(conv_result), .rd_start(rd_start), .rd_end(rd_end),
    .rd_chan(rd_chan), .mode_wr(mode_wr), .all_mode(all_mode), .chan_en(chan_en),
    .rd_data(rd_data), .rd_status(rd_status), .rdy_flags(rdy_flags), .rdy_n(rdy_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  // Monitor: compares read-out word against the scoreboard at each read start
  always @(posedge clk) begin
    if (rd_start) begin
      #2;
      if (exp_q.size() == 0) begin
        n_run++; n_fail++;
        $display("FAIL R2: actual read with empty scoreboard expected none");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk("R2 data", {8'h0, rd_data}, {8'h0, e.d});
        chk("R2 status", {24'h0, rd_status}, {24'h0, e.s});
      end
    end
  end

  task automatic conv(input logic [2:0] ch, input logic [23:0] v);
    @(negedge clk); conv_done = 1'b1; conv_chan = ch; conv_result = v;
    @(negedge clk); conv_done = 1'b0;
  endtask

  task automatic rd(input logic [2:0] ch, input logic [23:0] v);
    exp_q.push_back({v, 5'b0, ch});
    @(negedge clk); rd_start = 1'b1; rd_chan = ch;
    @(negedge clk); rd_start = 1'b0;
    @(negedge clk); rd_end = 1'b1;
    @(negedge clk); rd_end = 1'b0;
  endtask

  task automatic mwr();
    @(negedge clk); mode_wr = 1'b1;
    @(negedge clk); mode_wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 flags", rdy_flags, 0);
    chk("R1 pin", rdy_n, 1);
    chk("R1 data", rd_data, 0);

    // R2 / R4 any mode
    conv(3'd0, 24'h123456);
    chk("R2 flag", rdy_flags, 8'h01);
    chk("R4 pin low", rdy_n, 0);
    rd(3'd0, 24'h123456);
    chk("R3 cleared", rdy_flags, 0);
    chk("R4 pin high", rdy_n, 1);

    // R3 other channels untouched
    conv(3'd1, 24'hA1A1A1);
    conv(3'd2, 24'hB2B2B2);
    chk("R2 two flags", rdy_flags, 8'h06);
    rd(3'd1, 24'hA1A1A1);
    chk("R3 other kept", rdy_flags, 8'h04);
    chk("R4 still low", rdy_n, 0);
    rd(3'd2, 24'hB2B2B2);

    // R5 all mode
    all_mode = 1'b1; chan_en = 8'h03;
    conv(3'd0, 24'h000111);
    chk("R5 partial high", rdy_n, 1);
    conv(3'd1, 24'h000222);
    chk("R5 full low", rdy_n, 0);
    rd(3'd0, 24'h000111);
    chk("R5 after read high", rdy_n, 1);
    rd(3'd1, 24'h000222);
    chan_en = 8'h00;
    conv(3'd3, 24'h333333);
    chk("R5 none enabled", rdy_n, 1);
    all_mode = 1'b0; chan_en = 8'h03;
    @(negedge clk);
    chk("R4 any mode low", rdy_n, 0);
    rd(3'd3, 24'h333333);

    // R6 overwrite blackout
    conv(3'd5, 24'h550001);
    conv(3'd5, 24'h550002);
    chk("R6 pin forced", rdy_n, 1);
    chk("R6 flag dropped", rdy_flags, 0);
    repeat (HOLD - 1) @(negedge clk);
    chk("R6 last blackout", rdy_n, 1);
    @(negedge clk);
    chk("R6 pin released", rdy_n, 0);
    chk("R6 flag back", rdy_flags, 8'h20);
    rd(3'd5, 24'h550002);

    // R7 collision during read window
    conv(3'd4, 24'h440001);
    exp_q.push_back({24'h440001, 8'h04});
    @(negedge clk); rd_start = 1'b1; rd_chan = 3'd4;
    @(negedge clk); rd_start = 1'b0; conv_done = 1'b1; conv_chan = 3'd4; conv_result = 24'h440002;
    @(negedge clk); conv_done = 1'b0; rd_end = 1'b1;
    @(negedge clk); rd_end = 1'b0;
    chk("R7 flag not set", rdy_flags, 0);
    chk("R7 pin high", rdy_n, 1);
    rd(3'd4, 24'h440001);
    // conversion on the rd_end cycle
    conv(3'd4, 24'h440003);
    exp_q.push_back({24'h440003, 8'h04});
    @(negedge clk); rd_start = 1'b1; rd_chan = 3'd4;
    @(negedge clk); rd_start = 1'b0;
    @(negedge clk); rd_end = 1'b1; conv_done = 1'b1; conv_chan = 3'd4; conv_result = 24'h440004;
    @(negedge clk); rd_end = 1'b0; conv_done = 1'b0;
    chk("R7 end-cycle flag", rdy_flags, 0);
    rd(3'd4, 24'h440003);

    // R8 mode write clears
    conv(3'd6, 24'h660001);
    conv(3'd7, 24'h770001);
    chk("R8 pre flags", rdy_flags, 8'hC0);
    mwr();
    chk("R8 flags cleared", rdy_flags, 0);
    chk("R8 pin high", rdy_n, 1);
    conv(3'd6, 24'h660002);
    conv(3'd6, 24'h660003);
    mwr();
    repeat (HOLD + 4) @(negedge clk);
    chk("R8 pending dropped", rdy_flags, 0);
    chk("R8 pin stays high", rdy_n, 1);

    // R9 conversion with simultaneous mode write
    @(negedge clk); mode_wr = 1'b1; conv_done = 1'b1; conv_chan = 3'd2; conv_result = 24'hDEAD00;
    @(negedge clk); mode_wr = 1'b0; conv_done = 1'b0;
    chk("R9 flag", rdy_flags, 0);
    rd(3'd2, 24'hB2B2B2);

    repeat (4) @(negedge clk);
    chk("R2 scoreboard drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule